// File: doc/BRIEF.md
# Early-Addressed Synchronous Register File

This block holds the thirty-two general-purpose 32-bit registers of a pipelined processor. It has two read ports and one write port, and it is laid out so that it maps onto a synchronous block RAM. The read ports take their indices straight from the two source-register fields of the raw instruction word on the code bus. They capture those indices on the same clock edge that loads the instruction into the pipeline. Operand data is therefore already present when the instruction enters the decode/execute stage, and a small share of the decoding moves into the fetch cycle.

The write port belongs to the following stage and is driven by the writeback logic with an enable, an index and a word. A single global stall freezes the block. At a stalled edge the read outputs hold their values and any write offered at that edge is dropped, so the stage that owns the write must present it again. Index zero reads as zero in every case. The store is not cleared by reset, as is usual for block RAM; only the output registers are.

Top module: `early_regfile`

## Requirements
- R1: While `rst` is high at a rising edge, both `rd_a` and `rd_b` are zero after that edge, and no write is stored. Reset takes priority over stall.
- R2: At a rising edge with `stall` low, port A takes its index from `instr` bits 25:21 and port B from `instr` bits 20:16. The data for those indices is on `rd_a` and `rd_b` right after that same edge and stays there until the next non-stalled edge.
- R3: A read of index 0 returns zero on either port. A write to index 0 is discarded.
- R4: A write presented at a non-stalled, non-reset edge with `wr_en` high and `wr_addr` nonzero stores `wr_data`. Reads captured at later edges return that value until it is written again.
- R5: When a read on either port captures a nonzero index at the same edge where that index is written, the port returns the newly written data.
- R6: At a rising edge with `stall` high and `rst` low, `rd_a` and `rd_b` keep their previous values.
- R7: A write presented at an edge with `stall` high is not stored. A later read of that index returns the value it held before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of the output registers |
| instr | input | 32 | Raw instruction word from the code bus; bits 25:21 and 20:16 are the read indices |
| stall | input | 1 | Global pipeline stall; holds outputs and blocks writes |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Write index |
| wr_data | input | 32 | Write data |
| rd_a | output | 32 | Read data for the index in bits 25:21 |
| rd_b | output | 32 | Read data for the index in bits 20:16 |

## Verification
The bench checks the same-edge collision, where a read captures the index being written at that edge. A port that returned the stored word instead of the new one would hand the next instruction a stale operand. Stalled cycles are checked in two ways: the outputs must not move, and a write offered during the stall must not appear later. A design that let either one through would corrupt state on every cache refill. Index zero is checked both as a read target and as a write target, which catches a design that keeps data written to it. Reset is also applied in the middle of the run to confirm that it clears the outputs but not the stored registers.

// File: rtl/early_regfile_pkg.sv
package early_regfile_pkg;

    localparam int DATA_W   = 32;
    localparam int IDX_W    = 5;
    localparam int INSTR_W  = 32;
    localparam int SRC_A_LO = 21;
    localparam int SRC_B_LO = 16;
    localparam int NUM_RD   = 2;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [IDX_W-1:0]  idx_t;

    typedef struct packed {
        logic  en;
        idx_t  idx;
        word_t data;
    } wr_req_t;

    function automatic idx_t field_at(input logic [INSTR_W-1:0] w, input int lo);
        return w[lo +: IDX_W];
    endfunction

endpackage

// File: rtl/regfile_src_decode.sv
module regfile_src_decode
    import early_regfile_pkg::*;
#(
    parameter int N_PORTS = NUM_RD
) (
    input  logic [INSTR_W-1:0]          instr,
    output logic [N_PORTS-1:0][IDX_W-1:0] src_idx
);
    localparam int LO_A = SRC_A_LO;
    localparam int LO_B = SRC_B_LO;

    for (genvar p = 0; p < N_PORTS; p++) begin : g_field
        localparam int LO = (p == 0) ? LO_A : LO_B;
        assign src_idx[p] = field_at(instr, LO);
    end
endmodule

// File: rtl/regfile_store.sv
module regfile_store
    import early_regfile_pkg::*;
#(
    parameter int N_PORTS = NUM_RD,
    parameter int DEPTH   = 2**IDX_W
) (
    input  logic                          clk,
    input  logic                          commit,
    input  wr_req_t                       wr,
    input  logic [N_PORTS-1:0][IDX_W-1:0] rd_idx,
    output logic [N_PORTS-1:0][DATA_W-1:0] rd_raw
);
    word_t cells [DEPTH];

    always_ff @(posedge clk) begin
        if (commit && wr.en && (wr.idx != '0)) begin
            cells[wr.idx] <= wr.data;
        end
    end

    for (genvar p = 0; p < N_PORTS; p++) begin : g_rd
        assign rd_raw[p] = cells[rd_idx[p]];
    end
endmodule

// File: rtl/regfile_out_port.sv
module regfile_out_port
    import early_regfile_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    stall,
    input  idx_t    idx,
    input  word_t   raw,
    input  wr_req_t wr,
    output word_t   q
);
    word_t next_q;
    logic  collide;

    always_comb begin
        collide = wr.en && (wr.idx == idx);
        if (idx == '0)       next_q = '0;
        else if (collide)    next_q = wr.data;
        else                 next_q = raw;
    end

    always_ff @(posedge clk) begin
        if (rst)             q <= '0;
        else if (!stall)     q <= next_q;
    end
endmodule

// File: rtl/early_regfile.sv
module early_regfile
    import early_regfile_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [INSTR_W-1:0]  instr,
    input  logic                stall,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    output logic [DATA_W-1:0]   rd_a,
    output logic [DATA_W-1:0]   rd_b
);
    logic [NUM_RD-1:0][IDX_W-1:0]  src_idx;
    logic [NUM_RD-1:0][DATA_W-1:0] raw;
    logic [NUM_RD-1:0][DATA_W-1:0] port_q;
    wr_req_t wr;
    logic    commit;

    assign wr     = '{en: wr_en, idx: wr_addr, data: wr_data};
    assign commit = !rst && !stall;

    regfile_src_decode #(.N_PORTS(NUM_RD)) u_dec (
        .instr   (instr),
        .src_idx (src_idx)
    );

    regfile_store #(.N_PORTS(NUM_RD)) u_store (
        .clk    (clk),
        .commit (commit),
        .wr     (wr),
        .rd_idx (src_idx),
        .rd_raw (raw)
    );

    for (genvar p = 0; p < NUM_RD; p++) begin : g_port
        regfile_out_port u_port (
            .clk   (clk),
            .rst   (rst),
            .stall (stall),
            .idx   (src_idx[p]),
            .raw   (raw[p]),
            .wr    (wr),
            .q     (port_q[p])
        );
    end

    assign rd_a = port_q[0];
    assign rd_b = port_q[1];
endmodule

// File: rtl/early_regfile_checker.sv
module early_regfile_checker
    import early_regfile_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic [INSTR_W-1:0] instr,
    input logic               stall,
    input logic               wr_en,
    input logic [IDX_W-1:0]   wr_addr,
    input logic [DATA_W-1:0]  wr_data,
    input logic [DATA_W-1:0]  rd_a,
    input logic [DATA_W-1:0]  rd_b
);
    idx_t ia, ib;
    assign ia = instr[SRC_A_LO +: IDX_W];
    assign ib = instr[SRC_B_LO +: IDX_W];

    // R1
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (rd_a == '0) && (rd_b == '0));

    // R3
    a_r3_zero_read: assert property (@(posedge clk) disable iff (rst)
        (!stall && (ia == '0)) |=> (rd_a == '0));

    a_r3_zero_read_b: assert property (@(posedge clk) disable iff (rst)
        (!stall && (ib == '0)) |=> (rd_b == '0));

    // R5
    a_r5_bypass_a: assert property (@(posedge clk) disable iff (rst)
        (!stall && wr_en && (wr_addr != '0) && (wr_addr == ia))
        |=> (rd_a == $past(wr_data)));

    a_r5_bypass_b: assert property (@(posedge clk) disable iff (rst)
        (!stall && wr_en && (wr_addr != '0) && (wr_addr == ib))
        |=> (rd_b == $past(wr_data)));

    // R6
    a_r6_stall_hold: assert property (@(posedge clk) disable iff (rst)
        stall |=> ($stable(rd_a) && $stable(rd_b)));
endmodule

bind early_regfile early_regfile_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .instr   (instr),
    .stall   (stall),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_a    (rd_a),
    .rd_b    (rd_b)
);

// File: tb/tb_early_regfile.sv
module tb_early_regfile;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] instr = '0;
    logic        stall = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_a, rd_b;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    logic [31:0] model [32];
    bit          dropped [32];
    logic [31:0] exp_v [2];
    string       tag_v [2];
    bit          armed = 0;

    always #2.5 clk = ~clk;

    early_regfile dut (
        .clk(clk), .rst(rst), .instr(instr), .stall(stall),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_a(rd_a), .rd_b(rd_b)
    );

    // Reference model, evaluated on every rising edge from the inputs held there.
    always @(posedge clk) begin
        int idx [2];
        idx[0] = instr[25:21];
        idx[1] = instr[20:16];
        armed <= 1'b1;
        if (rst) begin
            for (int p = 0; p < 2; p++) begin exp_v[p] = '0; tag_v[p] = "R1"; end
        end else if (stall) begin
            for (int p = 0; p < 2; p++) tag_v[p] = "R6";
            if (wr_en && wr_addr != 0) dropped[wr_addr] = 1'b1;
        end else begin
            for (int p = 0; p < 2; p++) begin
                if (idx[p] == 0) begin
                    exp_v[p] = '0; tag_v[p] = "R3";
                end else if (wr_en && wr_addr == idx[p]) begin
                    exp_v[p] = wr_data; tag_v[p] = "R5";
                end else begin
                    exp_v[p] = model[idx[p]];
                    tag_v[p] = dropped[idx[p]] ? "R7" : (p == 0 ? "R2" : "R4");
                end
            end
            if (wr_en && wr_addr != 0) begin
                model[wr_addr] = wr_data;
                dropped[wr_addr] = 1'b0;
            end
        end
    end

    always @(negedge clk) begin
        cycles++;
        if (armed && !done) begin
            checks += 2;
            if (rd_a !== exp_v[0]) begin
                errors++;
                $display("FAIL %s port A actual %h expected %h", tag_v[0], rd_a, exp_v[0]);
            end
            if (rd_b !== exp_v[1]) begin
                errors++;
                $display("FAIL %s port B actual %h expected %h", tag_v[1], rd_b, exp_v[1]);
            end
        end
        if (cycles > 100000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog actual %0d cycles expected completion", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic step(input logic [4:0] a, input logic [4:0] b, input bit st,
                        input bit we, input logic [4:0] wa, input logic [31:0] wd);
        @(negedge clk);
        instr   = {6'h23, a, b, 16'h0000} ^ {6'h00, 10'h000, 16'($urandom)};
        stall   = st;
        wr_en   = we;
        wr_addr = wa;
        wr_data = wd;
    endtask

    initial begin
        for (int i = 0; i < 32; i++) dropped[i] = 1'b0;
        repeat (3) step(5'd0, 5'd0, 0, 0, 5'd0, '0);     // R1 reset state
        @(negedge clk); rst = 1'b0;
        for (int r = 1; r < 32; r++) step(5'd0, 5'd0, 0, 1, 5'(r), 32'hA500_0000 + r); // R4 fill
        step(5'd3, 5'd7, 0, 0, 5'd0, '0);                 // R2 plain reads
        step(5'd0, 5'd0, 0, 1, 5'd0, 32'hDEAD_BEEF);      // R3 write to zero
        step(5'd0, 5'd0, 0, 0, 5'd0, '0);
        step(5'd9, 5'd9, 0, 1, 5'd9, 32'h1234_5678);      // R5 both ports collide
        step(5'd4, 5'd5, 1, 1, 5'd4, 32'hFFFF_0000);      // R6 stall, R7 dropped write
        step(5'd6, 5'd8, 1, 0, 5'd0, '0);
        step(5'd4, 5'd5, 0, 0, 5'd0, '0);                 // R7 old value back
        for (int n = 0; n < 3000; n++) begin
            logic [4:0] a, b, wa;
            a  = 5'($urandom);
            b  = ($urandom_range(0, 3) == 0) ? a : 5'($urandom);
            wa = ($urandom_range(0, 2) == 0) ? a : 5'($urandom);
            step(a, b, $urandom_range(0, 4) == 0, $urandom_range(0, 1) == 1, wa, $urandom);
            if (n == 1500) begin
                @(negedge clk); rst = 1'b1;               // R1 mid-run reset
                @(negedge clk); rst = 1'b0;
            end
        end
        step(5'd0, 5'd0, 0, 0, 5'd0, '0);
        @(negedge clk);
        @(posedge clk);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule